// File: doc/BRIEF.md
# Address Translation Control and Status Unit

This block is the register front end of a small address translation unit. Software reaches it through a simple 32-bit register port with one write strobe and a combinational read path. The unit holds the base of the first-level translation table and turns command writes into moves of a four-state mode machine, which tracks translation on or off and requests held or released. It also turns command writes into one-cycle flush strobes for the translation engine. Software reads a status word back from the same port.

The unit also takes fault and bus-error events from the translation engine. On the first fault it latches the faulting address and the access direction, and it holds that fault until software acknowledges it. Each event sets a sticky bit in a raw interrupt word. A mask register gates the raw bits into a masked word, and the single interrupt line is the OR of the masked word. Every register and output is tied to one synchronous active-low reset.

Top module: `xlat_ctl_unit`

## Requirements
- R1: A write to the table base register (byte offset 0x00) keeps data bits 31:12 only, and bits 11:0 always read as zero: writing 0xCAFEBABE reads back 0xCAFEB000. `dir_base` carries the same value.
- R2: Command writes go to offset 0x08, with the code in data bits 2:0. Code 0 turns translation on and code 1 turns it off. Both `paging_on` and status bit 0 (read at offset 0x04) show the change in the cycle after the write.
- R3: Code 2 raises the hold request only while translation is on, and is ignored otherwise. Status bit 2 reports the hold and status bit 31 reads as its complement.
- R4: Code 3 releases the hold and leaves the translation setting unchanged. A hold taken with translation on and then kept through a code 1 ends with translation off.
- R5: Code 4 raises `flush_all` for exactly one cycle. A write to offset 0x10 raises `flush_line` for exactly one cycle, with data bits 31:12 on `flush_line_page`. Offsets 0x08, 0x10 and 0x18 read as zero.
- R6: Code 6 clears every register. The table base reads 0, translation and hold are off, the fault is cleared, and the raw word, the mask, the fault address and the gating bit read 0.
- R7: A fault event latches `evt_fault_addr` (read at 0x0C) and `evt_fault_write` (status bit 5). It sets status bit 1, `fault_pending` and raw interrupt bit 0 (read at 0x14). Status bit 1 stays set until code 5 is written, and status bit 5 keeps the direction of the last latched fault.
- R8: A fault event that arrives while a fault is pending is dropped, and the latched address is not overwritten.
- R9: A bus-error event sets raw bit 1. Writing ones to offset 0x18 clears those raw bits. An event and a clear of the same bit in the same cycle leave the bit set.
- R10: The mask register at 0x1C uses bits 1:0. Offset 0x20 reads the raw word AND the mask, and `irq` is the OR of that masked word.
- R11: Status bit 3 follows `eng_idle` and status bit 4 follows `replay_empty`, with no delay.
- R12: Command code 7 changes no state.
- R13: Bit 0 at offset 0x24 is a read/write gating enable that drives `gate_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| evt_fault | input | 1 | Translation fault event from the engine |
| evt_fault_addr | input | DATA_W | Address of the faulting access |
| evt_fault_write | input | 1 | Faulting access was a write |
| evt_bus_err | input | 1 | Bus read error event from the engine |
| eng_idle | input | 1 | Engine idle indication |
| replay_empty | input | 1 | Engine replay buffer empty indication |
| dir_base | output | DATA_W | Table base to the engine |
| paging_on | output | 1 | Translation enabled |
| stall_on | output | 1 | Hold request active |
| fault_pending | output | 1 | Fault latched and not yet acknowledged |
| flush_all | output | 1 | One-cycle whole-cache flush strobe |
| flush_line | output | 1 | One-cycle single-line flush strobe |
| flush_line_page | output | DATA_W-PAGE_SHIFT | Page number for the line flush |
| gate_en | output | 1 | Gating enable bit |
| irq | output | 1 | Interrupt, OR of the masked status |

## Verification
The bench builds the unit with the default parameters: a 6-bit byte address, 32-bit data, a 12-bit page offset and two interrupt sources. With these values all ten word offsets fall inside the decoded range, and the complemented hold flag sits at status bit 31. The line-flush page field is 20 bits wide. The directed sequence walks all four mode states, including a hold kept through a disable. The randomised phase mixes commands, mask writes, clears and events against a bench model of the mode, the fault latch and the raw word.

// File: rtl/xlat_ctl_pkg.sv
// Shared definitions for the translation control unit: register word
// indices, command codes, mode encoding and command strobe bundle.
package xlat_ctl_pkg;

    // Word index of each register (byte offset divided by four).
    localparam int IX_BASE   = 0;
    localparam int IX_STAT   = 1;
    localparam int IX_CMD    = 2;
    localparam int IX_FADDR  = 3;
    localparam int IX_LFLUSH = 4;
    localparam int IX_RAW    = 5;
    localparam int IX_CLR    = 6;
    localparam int IX_MASK   = 7;
    localparam int IX_MSKST  = 8;
    localparam int IX_GATE   = 9;
    localparam int REG_NUM   = 10;

    // Status bit positions (the complemented hold flag is the top bit).
    localparam int SB_PAGING = 0;
    localparam int SB_FAULT  = 1;
    localparam int SB_STALL  = 2;
    localparam int SB_IDLE   = 3;
    localparam int SB_REPLAY = 4;
    localparam int SB_FWRITE = 5;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_PG_ON  = 3'd0,
        CMD_PG_OFF = 3'd1,
        CMD_ST_ON  = 3'd2,
        CMD_ST_OFF = 3'd3,
        CMD_FLUSH  = 3'd4,
        CMD_FDONE  = 3'd5,
        CMD_FRESET = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        MD_IDLE     = 2'd0,  // translation off, no hold
        MD_RUN      = 2'd1,  // translation on, no hold
        MD_HOLD     = 2'd2,  // translation on, held
        MD_HOLD_OFF = 2'd3   // translation off, hold still asserted
    } mode_e;

    typedef struct packed {
        logic pg_on;
        logic pg_off;
        logic st_on;
        logic st_off;
        logic flush;
        logic fdone;
        logic freset;
    } cmd_strb_t;

endpackage

// File: rtl/xlat_cmd_decode.sv
// Command decoder: turns a write to the command register into one strobe
// per command. Assumes at most one register write per cycle; unknown
// codes produce no strobe.
module xlat_cmd_decode
    import xlat_ctl_pkg::*;
(
    input  logic             cmd_hit,
    input  logic [CMD_W-1:0] cmd_code,
    output cmd_strb_t        strb
);

    // Map the written code onto its single strobe.
    always_comb begin
        strb = '0;
        if (cmd_hit) begin
            case (cmd_e'(cmd_code))
                CMD_PG_ON:  strb.pg_on  = 1'b1;
                CMD_PG_OFF: strb.pg_off = 1'b1;
                CMD_ST_ON:  strb.st_on  = 1'b1;
                CMD_ST_OFF: strb.st_off = 1'b1;
                CMD_FLUSH:  strb.flush  = 1'b1;
                CMD_FDONE:  strb.fdone  = 1'b1;
                CMD_FRESET: strb.freset = 1'b1;
                default:    strb = '0;
            endcase
        end
    end

endmodule

// File: rtl/xlat_mode_ctl.sv
// Mode machine: tracks translation enable and hold request as four states
// and issues the whole-cache flush strobe. A hold request is only accepted
// while translation is on; releasing it leaves translation as it was.
module xlat_mode_ctl
    import xlat_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_strb_t strb,
    output logic      paging_on,
    output logic      stall_on,
    output logic      flush_all
);

    mode_e mode_q, mode_d;

    // Next-state selection from the command strobes.
    always_comb begin
        mode_d = mode_q;
        if (strb.freset) begin
            mode_d = MD_IDLE;
        end else if (strb.pg_on) begin
            case (mode_q)
                MD_IDLE:     mode_d = MD_RUN;
                MD_HOLD_OFF: mode_d = MD_HOLD;
                default:     mode_d = mode_q;
            endcase
        end else if (strb.pg_off) begin
            case (mode_q)
                MD_RUN:  mode_d = MD_IDLE;
                MD_HOLD: mode_d = MD_HOLD_OFF;
                default: mode_d = mode_q;
            endcase
        end else if (strb.st_on) begin
            if (mode_q == MD_RUN) mode_d = MD_HOLD;
        end else if (strb.st_off) begin
            case (mode_q)
                MD_HOLD:     mode_d = MD_RUN;
                MD_HOLD_OFF: mode_d = MD_IDLE;
                default:     mode_d = mode_q;
            endcase
        end
    end

    // Mode register and one-cycle flush strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MD_IDLE;
            flush_all <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            flush_all <= strb.flush;
        end
    end

    assign paging_on = (mode_q == MD_RUN)  || (mode_q == MD_HOLD);
    assign stall_on  = (mode_q == MD_HOLD) || (mode_q == MD_HOLD_OFF);

endmodule

// File: rtl/xlat_event_unit.sv
// Event unit: latches the first fault (address and direction) until it is
// acknowledged, keeps sticky raw interrupt bits with write-one-to-clear,
// holds the mask and forms the interrupt line. Bit 0 is the fault source,
// bit 1 the bus-error source; any further bits are never set. A set
// beats a clear of the same bit in the same cycle.
module xlat_event_unit #(
    parameter int DATA_W = 32,
    parameter int IRQ_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freset,
    input  logic              fdone,
    input  logic              mask_wr,
    input  logic              clr_wr,
    input  logic [IRQ_N-1:0]  wbits,
    input  logic              evt_fault,
    input  logic [DATA_W-1:0] evt_fault_addr,
    input  logic              evt_fault_write,
    input  logic              evt_bus_err,
    output logic [IRQ_N-1:0]  raw_q,
    output logic [IRQ_N-1:0]  mask_q,
    output logic              fault_pending,
    output logic [DATA_W-1:0] fault_addr,
    output logic              fault_write,
    output logic              irq
);

    logic             fault_take;
    logic [IRQ_N-1:0] set_v;

    assign fault_take = evt_fault && !fault_pending;

    // Collect the per-source set requests.
    always_comb begin
        set_v    = '0;
        set_v[0] = fault_take;
        set_v[1] = evt_bus_err;
    end

    // Fault latch and mask register.
    always_ff @(posedge clk) begin
        if (!rst_n || freset) begin
            fault_pending <= 1'b0;
            fault_addr    <= '0;
            fault_write   <= 1'b0;
            mask_q        <= '0;
        end else begin
            if (fault_take) begin
                fault_pending <= 1'b1;
                fault_addr    <= evt_fault_addr;
                fault_write   <= evt_fault_write;
            end else if (fdone) begin
                fault_pending <= 1'b0;
            end
            if (mask_wr) mask_q <= wbits;
        end
    end

    // One sticky raw bit per interrupt source.
    for (genvar i = 0; i < IRQ_N; i++) begin : g_raw
        always_ff @(posedge clk) begin
            if (!rst_n || freset) raw_q[i] <= 1'b0;
            else                  raw_q[i] <= set_v[i] | (raw_q[i] & ~(clr_wr & wbits[i]));
        end
    end

    assign irq = |(raw_q & mask_q);

endmodule

// File: rtl/xlat_ctl_unit.sv
// Top of the translation control unit: decodes the register port, holds
// the table base, gating bit and line-flush strobe, instantiates the
// command decoder, mode machine and event unit, and builds the read mux.
// Assumes word-aligned accesses; misaligned or unlisted addresses write
// nothing and read zero.
module xlat_ctl_unit
    import xlat_ctl_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int IRQ_N      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic                       evt_fault,
    input  logic [DATA_W-1:0]          evt_fault_addr,
    input  logic                       evt_fault_write,
    input  logic                       evt_bus_err,
    input  logic                       eng_idle,
    input  logic                       replay_empty,
    output logic [DATA_W-1:0]          dir_base,
    output logic                       paging_on,
    output logic                       stall_on,
    output logic                       fault_pending,
    output logic                       flush_all,
    output logic                       flush_line,
    output logic [DATA_W-PAGE_SHIFT-1:0] flush_line_page,
    output logic                       gate_en,
    output logic                       irq
);

    localparam int IDX_W  = ADDR_W - 2;
    localparam int PAGE_W = DATA_W - PAGE_SHIFT;

    logic [IDX_W-1:0]   reg_idx;
    logic [REG_NUM-1:0] wr_hit;
    logic [REG_NUM-1:0] rd_hit;
    cmd_strb_t          strb;
    logic [PAGE_W-1:0]  base_q;
    logic [IRQ_N-1:0]   raw_q;
    logic [IRQ_N-1:0]   mask_q;
    logic [DATA_W-1:0]  fault_addr;
    logic               fault_write;
    logic [DATA_W-1:0]  status_w;
    logic [8:0]         unused_wbits;
    logic [3:0]         unused_hits;

    assign reg_idx = reg_addr[ADDR_W-1:2];

    // One address comparator per register, shared by read and write.
    for (genvar i = 0; i < REG_NUM; i++) begin : g_hit
        assign rd_hit[i] = (reg_addr[1:0] == 2'b00) && (reg_idx == IDX_W'(i));
        assign wr_hit[i] = reg_wr && rd_hit[i];
    end

    assign unused_wbits = reg_wdata[PAGE_SHIFT-1:3];
    assign unused_hits  = {wr_hit[IX_STAT], wr_hit[IX_FADDR], wr_hit[IX_RAW], wr_hit[IX_MSKST]};

    xlat_cmd_decode u_dec (
        .cmd_hit  (wr_hit[IX_CMD]),
        .cmd_code (reg_wdata[CMD_W-1:0]),
        .strb     (strb)
    );

    xlat_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (strb),
        .paging_on (paging_on),
        .stall_on  (stall_on),
        .flush_all (flush_all)
    );

    xlat_event_unit #(
        .DATA_W (DATA_W),
        .IRQ_N  (IRQ_N)
    ) u_evt (
        .clk             (clk),
        .rst_n           (rst_n),
        .freset          (strb.freset),
        .fdone           (strb.fdone),
        .mask_wr         (wr_hit[IX_MASK]),
        .clr_wr          (wr_hit[IX_CLR]),
        .wbits           (reg_wdata[IRQ_N-1:0]),
        .evt_fault       (evt_fault),
        .evt_fault_addr  (evt_fault_addr),
        .evt_fault_write (evt_fault_write),
        .evt_bus_err     (evt_bus_err),
        .raw_q           (raw_q),
        .mask_q          (mask_q),
        .fault_pending   (fault_pending),
        .fault_addr      (fault_addr),
        .fault_write     (fault_write),
        .irq             (irq)
    );

    // Table base and gating bit, both cleared by the forced reset.
    always_ff @(posedge clk) begin
        if (!rst_n || strb.freset) begin
            base_q  <= '0;
            gate_en <= 1'b0;
        end else begin
            if (wr_hit[IX_BASE]) base_q  <= reg_wdata[DATA_W-1:PAGE_SHIFT];
            if (wr_hit[IX_GATE]) gate_en <= reg_wdata[0];
        end
    end

    // Single-line flush strobe with its page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_line      <= 1'b0;
            flush_line_page <= '0;
        end else begin
            flush_line <= wr_hit[IX_LFLUSH];
            if (wr_hit[IX_LFLUSH]) flush_line_page <= reg_wdata[DATA_W-1:PAGE_SHIFT];
        end
    end

    assign dir_base = {base_q, {PAGE_SHIFT{1'b0}}};

    // Assemble the status word.
    always_comb begin
        status_w            = '0;
        status_w[SB_PAGING] = paging_on;
        status_w[SB_FAULT]  = fault_pending;
        status_w[SB_STALL]  = stall_on;
        status_w[SB_IDLE]   = eng_idle;
        status_w[SB_REPLAY] = replay_empty;
        status_w[SB_FWRITE] = fault_write;
        status_w[DATA_W-1]  = !stall_on;
    end

    // Read mux; write-only and unlisted addresses return zero.
    always_comb begin
        reg_rdata = '0;
        if (rd_hit[IX_BASE])  reg_rdata = dir_base;
        if (rd_hit[IX_STAT])  reg_rdata = status_w;
        if (rd_hit[IX_FADDR]) reg_rdata = fault_addr;
        if (rd_hit[IX_RAW])   reg_rdata = {{(DATA_W-IRQ_N){1'b0}}, raw_q};
        if (rd_hit[IX_MASK])  reg_rdata = {{(DATA_W-IRQ_N){1'b0}}, mask_q};
        if (rd_hit[IX_MSKST]) reg_rdata = {{(DATA_W-IRQ_N){1'b0}}, raw_q & mask_q};
        if (rd_hit[IX_GATE])  reg_rdata = {{(DATA_W-1){1'b0}}, gate_en};
    end

endmodule

// File: rtl/xlat_ctl_checker.sv
// Checker for the translation control unit, bound to the top module.
// Relates command writes and events at the ports to the mode, base and
// fault outputs one cycle later.
module xlat_ctl_checker #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              evt_fault,
    input logic [DATA_W-1:0] dir_base,
    input logic              paging_on,
    input logic              stall_on,
    input logic              fault_pending,
    input logic              flush_all
);

    logic       cmd_w;
    logic       base_w;
    logic [2:0] code;

    assign cmd_w  = reg_wr && (reg_addr == ADDR_W'(8));
    assign base_w = reg_wr && (reg_addr == ADDR_W'(0));
    assign code   = reg_wdata[2:0];

    assert_base_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        base_w |=> dir_base[DATA_W-1:PAGE_SHIFT] == $past(reg_wdata[DATA_W-1:PAGE_SHIFT]));

    assert_paging_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && code == 3'd0) |=> paging_on);

    assert_paging_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && code == 3'd1) |=> !paging_on);

    assert_stall_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && code == 3'd2 && !paging_on && !stall_on) |=> !stall_on);

    assert_flush_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && code == 3'd4) |=> flush_all);

    assert_force_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && code == 3'd6) |=> (dir_base == '0) && !paging_on && !stall_on && !fault_pending);

    assert_fault_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_fault && !fault_pending && !(cmd_w && code == 3'd6)) |=> fault_pending);

    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pending && !(cmd_w && (code == 3'd5 || code == 3'd6))) |=> fault_pending);

endmodule

bind xlat_ctl_unit xlat_ctl_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (.*);

// File: tb/tb_xlat_ctl_unit.sv
// Bench for the translation control unit: directed corner cases followed
// by seeded random traffic checked against a bench model.
module tb_xlat_ctl_unit;

    logic        clk;
    logic        rst_n;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        evt_fault;
    logic [31:0] evt_fault_addr;
    logic        evt_fault_write;
    logic        evt_bus_err;
    logic        eng_idle;
    logic        replay_empty;
    logic [31:0] dir_base;
    logic        paging_on;
    logic        stall_on;
    logic        fault_pending;
    logic        flush_all;
    logic        flush_line;
    logic [19:0] flush_line_page;
    logic        gate_en;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Bench model state.
    bit          m_pg, m_st, m_pend, m_fw;
    logic [31:0] m_faddr, m_base;
    logic [1:0]  m_raw, m_mask;

    xlat_ctl_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_fault(evt_fault),
        .evt_fault_addr(evt_fault_addr), .evt_fault_write(evt_fault_write),
        .evt_bus_err(evt_bus_err), .eng_idle(eng_idle), .replay_empty(replay_empty),
        .dir_base(dir_base), .paging_on(paging_on), .stall_on(stall_on),
        .fault_pending(fault_pending), .flush_all(flush_all), .flush_line(flush_line),
        .flush_line_page(flush_line_page), .gate_en(gate_en), .irq(irq)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fault_evt(input logic [31:0] a, input bit w);
        @(negedge clk);
        evt_fault = 1'b1; evt_fault_addr = a; evt_fault_write = w;
        @(negedge clk);
        evt_fault = 1'b0;
    endtask

    task automatic clr_with_bus(input logic [1:0] bits);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 6'h18; reg_wdata = {30'd0, bits}; evt_bus_err = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_bus_err = 1'b0;
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s = '0;
        s[0] = m_pg; s[1] = m_pend; s[2] = m_st;
        s[3] = eng_idle; s[4] = replay_empty; s[5] = m_fw;
        s[31] = !m_st;
        return s;
    endfunction

    task automatic model_cmd(input logic [2:0] c);
        case (c)
            3'd0: m_pg = 1;
            3'd1: m_pg = 0;
            3'd2: if (m_pg) m_st = 1;
            3'd3: m_st = 0;
            3'd5: m_pend = 0;
            3'd6: begin
                m_pg = 0; m_st = 0; m_pend = 0; m_fw = 0; m_faddr = 0;
                m_base = 0; m_raw = 0; m_mask = 0;
            end
            default: ;
        endcase
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0; evt_fault = 0; evt_fault_addr = 0;
        evt_fault_write = 0; evt_bus_err = 0; eng_idle = 1; replay_empty = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // Reset state.
        rd(6'h04, d); chk("R2 reset status", d, 32'h8000_0018);
        chk("R10 reset irq", {31'd0, irq}, 0);
        chk("R1 reset base", dir_base, 0);

        // R1: low bits of the base read as zero.
        wr(6'h00, 32'hCAFE_BABE);
        rd(6'h00, d); chk("R1 base readback", d, 32'hCAFE_B000);
        chk("R1 dir_base port", dir_base, 32'hCAFE_B000);

        // R3: hold ignored with translation off.
        wr(6'h08, 32'd2);
        rd(6'h04, d); chk("R3 hold ignored when off", d, 32'h8000_0018);

        // R2: translation on.
        wr(6'h08, 32'd0);
        rd(6'h04, d); chk("R2 paging on status", d, 32'h8000_0019);
        chk("R2 paging_on port", {31'd0, paging_on}, 1);

        // R3: hold taken, top bit cleared.
        wr(6'h08, 32'd2);
        rd(6'h04, d); chk("R3 hold status", d, 32'h0000_001D);

        // R4: release keeps translation on.
        wr(6'h08, 32'd3);
        rd(6'h04, d); chk("R4 release status", d, 32'h8000_0019);

        // R4: hold kept through disable, then released.
        wr(6'h08, 32'd2);
        wr(6'h08, 32'd1);
        rd(6'h04, d); chk("R4 held while off", d, 32'h0000_001C);
        wr(6'h08, 32'd3);
        rd(6'h04, d); chk("R4 released to off", d, 32'h8000_0018);
        wr(6'h08, 32'd0);

        // R5: flush strobes last one cycle; write-only regs read zero.
        wr(6'h08, 32'd4);
        chk("R5 flush_all high", {31'd0, flush_all}, 1);
        @(negedge clk);
        chk("R5 flush_all one cycle", {31'd0, flush_all}, 0);
        wr(6'h10, 32'h1234_5678);
        chk("R5 flush_line high", {31'd0, flush_line}, 1);
        chk("R5 flush_line_page", {12'd0, flush_line_page}, 32'h0001_2345);
        @(negedge clk);
        chk("R5 flush_line one cycle", {31'd0, flush_line}, 0);
        rd(6'h08, d); chk("R5 cmd reads zero", d, 0);
        rd(6'h10, d); chk("R5 line reg reads zero", d, 0);
        rd(6'h18, d); chk("R5 clear reg reads zero", d, 0);

        // R7: fault latched.
        fault_evt(32'hDEAD_1234, 1'b1);
        rd(6'h04, d); chk("R7 fault status", d, 32'h8000_003B);
        rd(6'h0C, d); chk("R7 fault address", d, 32'hDEAD_1234);
        rd(6'h14, d); chk("R7 raw fault bit", d, 32'd1);
        chk("R10 irq masked off", {31'd0, irq}, 0);

        // R8: second fault dropped.
        fault_evt(32'h1111_0000, 1'b0);
        rd(6'h0C, d); chk("R8 address kept", d, 32'hDEAD_1234);
        rd(6'h04, d); chk("R8 status kept", d, 32'h8000_003B);

        // R10: mask gates raw into masked word and irq.
        wr(6'h1C, 32'd3);
        rd(6'h20, d); chk("R10 masked status", d, 32'd1);
        chk("R10 irq on", {31'd0, irq}, 1);

        // R9: bus error with clear of the fault bit.
        clr_with_bus(2'b01);
        rd(6'h14, d); chk("R9 clear bit0 set bit1", d, 32'd2);
        clr_with_bus(2'b10);
        rd(6'h14, d); chk("R9 set beats clear", d, 32'd2);
        wr(6'h18, 32'd2);
        rd(6'h14, d); chk("R9 cleared", d, 32'd0);
        chk("R10 irq off after clear", {31'd0, irq}, 0);

        // R7: fault acknowledged, direction kept.
        wr(6'h08, 32'd5);
        rd(6'h04, d); chk("R7 fault done", d, 32'h8000_0039);

        // R12: unknown code.
        wr(6'h08, 32'd7);
        rd(6'h04, d); chk("R12 code 7 ignored", d, 32'h8000_0039);

        // R13: gating bit.
        wr(6'h24, 32'd1);
        rd(6'h24, d); chk("R13 gate readback", d, 32'd1);
        chk("R13 gate_en port", {31'd0, gate_en}, 1);

        // R11: status mirrors engine inputs.
        @(negedge clk); eng_idle = 0; replay_empty = 0;
        rd(6'h04, d); chk("R11 idle and replay low", d, 32'h8000_0021);
        eng_idle = 1; replay_empty = 1;

        // R6: forced reset.
        wr(6'h08, 32'd2);
        wr(6'h08, 32'd6);
        rd(6'h04, d); chk("R6 status after reset", d, 32'h8000_0018);
        rd(6'h00, d); chk("R6 base zero", d, 0);
        rd(6'h1C, d); chk("R6 mask zero", d, 0);
        rd(6'h24, d); chk("R6 gate zero", d, 0);
        rd(6'h0C, d); chk("R6 fault address zero", d, 0);

        // Random phase against the model.
        m_pg = 0; m_st = 0; m_pend = 0; m_fw = 0; m_faddr = 0; m_base = 0; m_raw = 0; m_mask = 0;
        void'($urandom(32'd20240611));
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] v;
            op = $urandom_range(0, 5);
            v  = $urandom;
            case (op)
                0: begin wr(6'h08, {29'd0, v[2:0]}); model_cmd(v[2:0]); end
                1: begin wr(6'h1C, v); m_mask = v[1:0]; end
                2: begin wr(6'h18, v); m_raw = m_raw & ~v[1:0]; end
                3: begin
                    fault_evt(v, v[0]);
                    if (!m_pend) begin m_pend = 1; m_faddr = v; m_fw = v[0]; m_raw[0] = 1; end
                end
                4: begin
                    @(negedge clk); evt_bus_err = 1; @(negedge clk); evt_bus_err = 0;
                    m_raw[1] = 1;
                end
                default: begin wr(6'h00, v); m_base = v & 32'hFFFF_F000; end
            endcase
            eng_idle = v[5]; replay_empty = v[6];
            rd(6'h04, d); chk("R2 R3 R7 random status", d, exp_status());
            rd(6'h14, d); chk("R9 random raw", d, {30'd0, m_raw});
            rd(6'h20, d); chk("R10 random masked", d, {30'd0, m_raw & m_mask});
            chk("R10 random irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
            rd(6'h0C, d); chk("R8 random fault address", d, m_faddr);
            chk("R1 random base", dir_base, m_base);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule